// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a word-wide flash memory model. It watches the bus write cycles that a host makes (address, data word, write strobe) and recognises the unlock-prefixed command sequences. A recognised sequence becomes a single-cycle start pulse for one internal operation: word program, chip erase, sector erase or boot-block lockout. Two further sequences move the device into and out of product identification mode.

Each sequence begins with a two-write unlock prefix. The third write picks the command. Erase-class commands need a second unlock prefix before a sixth write that names the operation. A write that does not fit the expected step drops the sequence. A read that arrives partway through a sequence also drops it and returns the device to read mode. While the internal engine reports busy, writes are ignored.

The decoder keeps a boot-block lock flag. Once the lock is set, program and erase requests never touch the boot block. The erase start pulses carry a block mask that tells the array which blocks to clear.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset all start pulses are low, `erase_mask` is 0, `id_mode` is 0 and `boot_locked` is 0.
- R2: Writes of 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, followed by a write of D to address A, make `prog_go` high for exactly the cycle after the fourth write is sampled, with `prog_addr`=A and `prog_data`=D (all 16 data bits).
- R3: Command writes compare only address bits 14..0 and data bits 7..0. Bits 16..15 of the address and bits 15..8 of the data have no effect on recognition.
- R4: Unlock pair, 0x80 to 0x5555, unlock pair, then 0x10 to 0x5555 pulses `chip_erase_go`. The mask bit order is bit0 boot, bit1 first parameter block, bit2 second parameter block, bit3 main block. The mask is 4'b1111 when unlocked and 4'b1110 when locked.
- R5: The same six-write prefix ending in 0x30 written to address S pulses `sect_erase_go`. The block is chosen by S[16:13]: 0 is boot, 1 is the first parameter block, 2 is the second parameter block, and 3 or more is the main block. When unlocked the masks are 0001, 0010, 0100, and 1001 for main (the main erase also clears boot).
- R6: The six-write prefix ending in 0x40 to 0x5555 pulses `lock_go`. `boot_locked` is 1 from that same cycle and stays 1 until reset.
- R7: While `boot_locked` is 1, no pulse is issued for a program into the boot block or for a sector erase of the boot block. A main-block sector erase then has mask 4'b1000.
- R8: Unlock pair then 0x90 to 0x5555 sets `id_mode`. Unlock pair then 0xF0 to 0x5555 clears it.
- R9: A write that does not match the expected step returns the decoder to idle without any pulse. A complete sequence that follows is recognised normally.
- R10: A read (`rd_en`) while a sequence is in progress abandons it and clears `id_mode`. The writes that then finish the old sequence produce no pulse.
- R11: A write while `busy` is 1 neither advances nor abandons the sequence in progress and produces no pulse.
- R12: At most one start pulse is high in any cycle, and no start pulse lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 17 | Write word address |
| wr_data | input | 16 | Write data word |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| busy | input | 1 | Internal program/erase engine busy |
| prog_go | output | 1 | Word program start pulse |
| prog_addr | output | 17 | Program target address |
| prog_data | output | 16 | Program data |
| chip_erase_go | output | 1 | Chip erase start pulse |
| sect_erase_go | output | 1 | Sector erase start pulse |
| erase_mask | output | 4 | Blocks to erase, valid with an erase pulse |
| lock_go | output | 1 | Boot-block lockout start pulse |
| id_mode | output | 1 | Product identification mode active |
| boot_locked | output | 1 | Boot block locked |

## Verification
The hardest situations to reach are the interleavings within a sequence. These are a read, or a write made while busy, that lands between the unlock writes and the command write, and a protected request once the lock flag is set. The stimulus places a read or a busy-qualified junk write inside a half-finished sequence. It then completes the remaining writes and checks whether a pulse appears. The lockout sequence is issued partway through the run, and the same boot and main requests are repeated after it to compare masks and suppressed pulses.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int CMD_AW  = 15;
    localparam int NUM_BLK = 4;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] OP_UNL_A  = 8'hAA;
    localparam logic [7:0] OP_UNL_B  = 8'h55;
    localparam logic [7:0] OP_PROG   = 8'hA0;
    localparam logic [7:0] OP_ERPRE  = 8'h80;
    localparam logic [7:0] OP_IDIN   = 8'h90;
    localparam logic [7:0] OP_IDOUT  = 8'hF0;
    localparam logic [7:0] OP_CHIP   = 8'h10;
    localparam logic [7:0] OP_SECT   = 8'h30;
    localparam logic [7:0] OP_LOCK   = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERA3,
        ST_ERA4,
        ST_ERA5
    } seq_state_e;

    typedef enum logic [1:0] {
        BLK_BOOT = 2'd0,
        BLK_PAR1 = 2'd1,
        BLK_PAR2 = 2'd2,
        BLK_MAIN = 2'd3
    } blk_e;

endpackage

// File: rtl/fcs_cmd_match.sv
module fcs_cmd_match
    import fcs_pkg::*;
(
    input  logic [CMD_AW-1:0] addr_lo,
    input  logic [7:0]        data_lo,
    output logic              at_key_a,
    output logic              at_key_b,
    output logic [7:0]        op
);
    always_comb begin
        at_key_a = (addr_lo == KEY_ADDR_A);
        at_key_b = (addr_lo == KEY_ADDR_B);
        op       = data_lo;
    end
endmodule

// File: rtl/fcs_sector_map.sv
module fcs_sector_map
    import fcs_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] blk_idx,
    output blk_e             blk
);
    always_comb begin
        if (blk_idx == IDX_W'(0))      blk = BLK_BOOT;
        else if (blk_idx == IDX_W'(1)) blk = BLK_PAR1;
        else if (blk_idx == IDX_W'(2)) blk = BLK_PAR2;
        else                           blk = BLK_MAIN;
    end
endmodule

// File: rtl/fcs_protect.sv
module fcs_protect
    import fcs_pkg::*;
(
    input  blk_e               blk,
    input  logic               locked,
    output logic               prog_ok,
    output logic [NUM_BLK-1:0] sect_mask,
    output logic [NUM_BLK-1:0] chip_mask
);
    logic [NUM_BLK-1:0] all_blk;
    logic [NUM_BLK-1:0] boot_bit;

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_bits
        assign all_blk[g]  = 1'b1;
        assign boot_bit[g] = (g == int'(BLK_BOOT));
    end

    always_comb begin
        prog_ok   = !(locked && blk == BLK_BOOT);
        chip_mask = locked ? (all_blk & ~boot_bit) : all_blk;
        sect_mask = '0;
        sect_mask[blk] = 1'b1;
        if (blk == BLK_BOOT && locked)
            sect_mask = '0;
        else if (blk == BLK_MAIN && !locked)
            sect_mask = sect_mask | boot_bit;
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              busy,
    output logic              prog_go,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              chip_erase_go,
    output logic              sect_erase_go,
    output logic [NUM_BLK-1:0] erase_mask,
    output logic              lock_go,
    output logic              id_mode,
    output logic              boot_locked
);
    localparam int IDX_W = ADDR_W - BLK_W;

    typedef struct packed {
        seq_state_e         st;
        logic               id_mode;
        logic               locked;
        logic               prog_go;
        logic               chip_go;
        logic               sect_go;
        logic               lock_go;
        logic [NUM_BLK-1:0] mask;
        logic [ADDR_W-1:0]  paddr;
        logic [DATA_W-1:0]  pdata;
    } dec_t;

    dec_t state_d, state_q;

    logic               at_key_a, at_key_b;
    logic [7:0]         op;
    blk_e               blk;
    logic               prog_ok;
    logic [NUM_BLK-1:0] sect_mask, chip_mask;

    fcs_cmd_match u_match (
        .addr_lo  (wr_addr[CMD_AW-1:0]),
        .data_lo  (wr_data[7:0]),
        .at_key_a (at_key_a),
        .at_key_b (at_key_b),
        .op       (op)
    );

    fcs_sector_map #(.IDX_W(IDX_W)) u_map (
        .blk_idx (wr_addr[ADDR_W-1:BLK_W]),
        .blk     (blk)
    );

    fcs_protect u_prot (
        .blk       (blk),
        .locked    (state_q.locked),
        .prog_ok   (prog_ok),
        .sect_mask (sect_mask),
        .chip_mask (chip_mask)
    );

    always_comb begin
        state_d         = state_q;
        state_d.prog_go = 1'b0;
        state_d.chip_go = 1'b0;
        state_d.sect_go = 1'b0;
        state_d.lock_go = 1'b0;
        state_d.mask    = '0;
        if (rd_en) begin
            if (state_q.st != ST_IDLE) begin
                state_d.st      = ST_IDLE;
                state_d.id_mode = 1'b0;
            end
        end else if (wr_en && !busy) begin
            state_d.st = ST_IDLE;
            unique case (state_q.st)
                ST_IDLE: if (at_key_a && op == OP_UNL_A) state_d.st = ST_UNL1;
                ST_UNL1: if (at_key_b && op == OP_UNL_B) state_d.st = ST_UNL2;
                ST_UNL2: begin
                    if (at_key_a) begin
                        if (op == OP_PROG)       state_d.st = ST_PROG;
                        else if (op == OP_ERPRE) state_d.st = ST_ERA3;
                        else if (op == OP_IDIN)  state_d.id_mode = 1'b1;
                        else if (op == OP_IDOUT) state_d.id_mode = 1'b0;
                    end
                end
                ST_PROG: begin
                    if (prog_ok) begin
                        state_d.prog_go = 1'b1;
                        state_d.paddr   = wr_addr;
                        state_d.pdata   = wr_data;
                    end
                end
                ST_ERA3: if (at_key_a && op == OP_UNL_A) state_d.st = ST_ERA4;
                ST_ERA4: if (at_key_b && op == OP_UNL_B) state_d.st = ST_ERA5;
                ST_ERA5: begin
                    if (op == OP_SECT) begin
                        if (sect_mask != '0) begin
                            state_d.sect_go = 1'b1;
                            state_d.mask    = sect_mask;
                        end
                    end else if (at_key_a && op == OP_CHIP) begin
                        state_d.chip_go = 1'b1;
                        state_d.mask    = chip_mask;
                    end else if (at_key_a && op == OP_LOCK) begin
                        state_d.lock_go = 1'b1;
                        state_d.locked  = 1'b1;
                    end
                end
                default: state_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.st <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign prog_go       = state_q.prog_go;
    assign prog_addr     = state_q.paddr;
    assign prog_data     = state_q.pdata;
    assign chip_erase_go = state_q.chip_go;
    assign sect_erase_go = state_q.sect_go;
    assign erase_mask    = state_q.mask;
    assign lock_go       = state_q.lock_go;
    assign id_mode       = state_q.id_mode;
    assign boot_locked   = state_q.locked;

    logic any_go;
    assign any_go = prog_go | chip_erase_go | sect_erase_go | lock_go;

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_go, chip_erase_go, sect_erase_go, lock_go})); // R12
    AST_START_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        any_go |=> !any_go); // R12
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked); // R6
    AST_LOCK_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n)
        lock_go |-> boot_locked); // R6
    AST_BOOT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_locked && (chip_erase_go || sect_erase_go)) |-> !erase_mask[0]); // R7
    AST_SECT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        sect_erase_go |-> (erase_mask != '0)); // R5
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_en) |=> !any_go); // R11
    AST_READ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (!any_go && state_q.st == ST_IDLE)); // R10
    AST_READ_ID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && state_q.st != ST_IDLE) |=> !id_mode); // R10

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        busy = 1'b0;
    logic        prog_go, chip_erase_go, sect_erase_go, lock_go, id_mode, boot_locked;
    logic [16:0] prog_addr;
    logic [15:0] prog_data;
    logic [3:0]  erase_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .busy(busy), .prog_go(prog_go), .prog_addr(prog_addr),
        .prog_data(prog_data), .chip_erase_go(chip_erase_go), .sect_erase_go(sect_erase_go),
        .erase_mask(erase_mask), .lock_go(lock_go), .id_mode(id_mode), .boot_locked(boot_locked)
    );

    typedef struct {
        int          kind;   // 0 program, 1 chip erase, 2 sector erase, 3 lockout
        logic [16:0] addr;
        logic [15:0] data;
        logic [3:0]  mask;
    } exp_t;

    exp_t  sb[$];
    int    nvec = 0;
    int    nbad = 0;
    int    seen = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic fail_msg(string req, string what, int act, int expv);
        nbad++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    endtask

    task automatic chk(string req, string what, int act, int expv);
        nvec++;
        if (act != expv) fail_msg(req, what, act, expv);
    endtask

    always @(negedge clk) begin
        exp_t e;
        int   k;
        if (rst_n && !done && (prog_go | chip_erase_go | sect_erase_go | lock_go)) begin
            seen++;
            k = prog_go ? 0 : chip_erase_go ? 1 : sect_erase_go ? 2 : 3;
            nvec++;
            if (sb.size() == 0) begin
                fail_msg(cur_req, "unexpected start pulse kind", k, 99);
            end else begin
                e = sb.pop_front();
                if (k != e.kind) fail_msg(cur_req, "pulse kind", k, e.kind);
                else if (k == 0 && (prog_addr != e.addr || prog_data != e.data))
                    fail_msg(cur_req, "program addr/data", {prog_addr, prog_data}, {e.addr, e.data});
                else if ((k == 1 || k == 2) && erase_mask != e.mask)
                    fail_msg(cur_req, "erase mask", erase_mask, e.mask);
            end
        end
    end

    task automatic expect_go(int kind, logic [16:0] a, logic [15:0] d, logic [3:0] m);
        exp_t e;
        e.kind = kind; e.addr = a; e.data = d; e.mask = m;
        sb.push_back(e);
    endtask

    task automatic wr(logic [16:0] a, logic [15:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unl();
        wr(17'h05555, 16'h00AA);
        wr(17'h02AAA, 16'h0055);
    endtask

    task automatic pre6();
        unl();
        wr(17'h05555, 16'h0080);
        unl();
    endtask

    task automatic quiet_check(string req, int snap);
        repeat (2) @(negedge clk);
        chk(req, "no start pulse issued", seen - snap, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "id_mode", id_mode, 0);
        chk("R1", "boot_locked", boot_locked, 0);
        chk("R1", "pulses+mask", {prog_go, chip_erase_go, sect_erase_go, lock_go, erase_mask}, 0);

        // R2 word program
        cur_req = "R2";
        unl(); wr(17'h05555, 16'h00A0);
        expect_go(0, 17'h0ABCD, 16'h1234, 4'h0);
        wr(17'h0ABCD, 16'h1234);
        @(negedge clk);

        // R3 aliased address bits and upper data byte
        cur_req = "R3";
        wr(17'h1D555, 16'h3CAA); wr(17'h0AAAA, 16'hFF55); wr(17'h15555, 16'h77A0);
        expect_go(0, 17'h04000, 16'hFFFF, 4'h0);
        wr(17'h04000, 16'hFFFF);
        @(negedge clk);

        // R4 chip erase unlocked
        cur_req = "R4";
        pre6(); expect_go(1, 0, 0, 4'b1111); wr(17'h05555, 16'h0010);
        // R5 sector erase for each block
        cur_req = "R5";
        pre6(); expect_go(2, 0, 0, 4'b0010); wr(17'h02100, 16'h0030);
        pre6(); expect_go(2, 0, 0, 4'b0100); wr(17'h05FFF, 16'h0030);
        pre6(); expect_go(2, 0, 0, 4'b1001); wr(17'h1F000, 16'h0030);
        pre6(); expect_go(2, 0, 0, 4'b0001); wr(17'h00010, 16'h0030);
        @(negedge clk);

        // R8 product ID entry and exit
        cur_req = "R8";
        unl(); wr(17'h05555, 16'h0090);
        chk("R8", "id_mode after entry", id_mode, 1);
        rd(); chk("R8", "id_mode kept over idle read", id_mode, 1);
        unl(); wr(17'h05555, 16'h00F0);
        chk("R8", "id_mode after exit", id_mode, 0);

        // R9 mismatched step
        cur_req = "R9";
        snap = seen;
        unl(); wr(17'h05555, 16'h0077);
        wr(17'h05555, 16'h00A0); wr(17'h06000, 16'h0001);
        unl(); wr(17'h05555, 16'h0080); wr(17'h02AAA, 16'h0055); wr(17'h05555, 16'h0010);
        quiet_check("R9", snap);
        unl(); wr(17'h05555, 16'h00A0);
        expect_go(0, 17'h06000, 16'h0002, 4'h0);
        wr(17'h06000, 16'h0002);
        @(negedge clk);

        // R10 read mid-sequence
        cur_req = "R10";
        unl(); wr(17'h05555, 16'h0090);
        snap = seen;
        unl(); rd();
        chk("R10", "id_mode cleared by read", id_mode, 0);
        wr(17'h05555, 16'h00A0); wr(17'h06002, 16'h0003);
        pre6(); rd(); wr(17'h05555, 16'h0010);
        quiet_check("R10", snap);

        // R11 writes while busy
        cur_req = "R11";
        unl();
        busy = 1'b1;
        wr(17'h00000, 16'h1234);
        wr(17'h05555, 16'h00AA);
        busy = 1'b0;
        wr(17'h05555, 16'h00A0);
        expect_go(0, 17'h1ABCD, 16'h5A5A, 4'h0);
        wr(17'h1ABCD, 16'h5A5A);
        @(negedge clk);
        chk("R11", "busy writes left sequence intact", sb.size(), 0);

        // R6 lockout
        cur_req = "R6";
        pre6(); expect_go(3, 0, 0, 4'h0); wr(17'h05555, 16'h0040);
        chk("R6", "boot_locked with lock pulse", boot_locked, 1);
        repeat (3) @(negedge clk);
        chk("R6", "boot_locked sticky", boot_locked, 1);

        // R7 protection once locked
        cur_req = "R7";
        snap = seen;
        unl(); wr(17'h05555, 16'h00A0); wr(17'h00100, 16'h0BAD);
        pre6(); wr(17'h01FFF, 16'h0030);
        quiet_check("R7", snap);
        pre6(); expect_go(2, 0, 0, 4'b1000); wr(17'h1F000, 16'h0030);
        cur_req = "R4";
        pre6(); expect_go(1, 0, 0, 4'b1110); wr(17'h05555, 16'h0010);
        cur_req = "R7";
        unl(); wr(17'h05555, 16'h00A0);
        expect_go(0, 17'h02000, 16'h00C3, 4'h0);
        wr(17'h02000, 16'h00C3);
        repeat (2) @(negedge clk);

        chk("R12", "expected pulses all seen", sb.size(), 0);
        chk("R6", "boot_locked at end", boot_locked, 1);
        finish_run();
    end
endmodule